// File: doc/BRIEF.md
# Memory-window IDE bus bridge

This block lets a 68000-style processor reach an IDE (ATA) drive through a ROM address window that is already decoded on the board. The window select is active across the whole 4 MB ROM region, but the ROM itself answers only in the half where address bit 20 is low. The bridge claims the other half, where bit 20 is high. As a result the ROM appears near 0x400000 and the sixteen drive registers appear near 0x500000.

The ROM sockets carry no usable direction line, so the bridge uses address bit 4 as a read/write alias. When bit 4 is clear the access is a drive read. When bit 4 is set the access is a drive write. The CPU read/write line has to agree with the alias before any drive strobe fires. If the two disagree, the bridge acknowledges the access and touches nothing. Address bits 3..1 select one of eight registers, and bit 5 picks one of the two chip selects. Bit 0 is not used, because the bus is word-addressed.

Each drive cycle is run by a small state machine:
- It starts in IDLE.
- IDLE moves to SETUP when the access is selected and the direction agrees with the alias. It moves to SKIP when the access is selected and the direction does not agree.
- SETUP always moves to ACTIVE.
- ACTIVE moves to ACK after `STROBE_CLKS` clocks.
- ACK and SKIP both return to IDLE once the CPU ends its cycle.

The drive is polled, so there is no interrupt or DMA path. Reset is passed to the drive.

Top module: `ide_window_bridge`

## Requirements
- R1: A cycle starts only when `win_sel_n` is low, `cpu_win_a` (address bit 20) is high and at least one bit of `cpu_ds_n` is low. In every other case, no drive strobe, chip select or acknowledge is produced.
- R2: While a cycle runs, `ide_addr` equals `cpu_addr[3:1]` as captured when the cycle began.
- R3: `cpu_addr[5]`=0 selects `ide_cs0_n` and `cpu_addr[5]`=1 selects `ide_cs1_n`. The two chip selects are never low together.
- R4: `cpu_addr[4]`=0 is the read alias and drives `ide_rd_n` when `cpu_rw`=1. `cpu_addr[4]`=1 is the write alias and drives `ide_wr_n` when `cpu_rw`=0.
- R5: When the alias and `cpu_rw` disagree, the bridge takes the SKIP path. No drive strobe fires, `cpu_dtack_n` goes low one clock after selection, and `cpu_doe` stays low.
- R6: Chip select and register address are driven for one clock (SETUP) before the strobe falls. The strobe rises one clock (ACK) before either of them changes.
- R7: The drive strobe stays low for exactly `STROBE_CLKS` clocks. `cpu_dtack_n` falls in the clock after the strobe rises, which is `STROBE_CLKS`+2 clock edges after selection is first seen.
- R8: Read data is captured on the last strobe clock and held on `cpu_dout` until the cycle ends. A byte lane whose data strobe was inactive reads as zero (`cpu_ds_n[1]` is bits 15:8, `cpu_ds_n[0]` is bits 7:0). `cpu_doe` is high only in ACK for a read while the access is still selected.
- R9: On a drive write, `ide_dout` carries `cpu_din` as captured at cycle start. `ide_doe` is high while the chip select is held.
- R10: `ide_rst_n` follows `rst_n`. While reset is low, all strobes, chip selects and acknowledges are inactive.
- R11: The acknowledge holds while the CPU keeps the access selected, and no second drive cycle starts. When the selection drops, `cpu_dtack_n` and `cpu_doe` release at once and the chip selects release at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | System reset, active low |
| win_sel_n | input | 1 | ROM window select, active low |
| cpu_win_a | input | 1 | CPU address bit 20 |
| cpu_addr | input | REG_W+2 | CPU address bits 5..1 |
| cpu_rw | input | 1 | CPU direction, 1 = read |
| cpu_ds_n | input | DATA_W/LANE_W | Byte data strobes, active low, bit 1 = upper |
| cpu_din | input | DATA_W | Write data from CPU |
| cpu_dout | output | DATA_W | Read data to CPU |
| cpu_doe | output | 1 | CPU data bus drive enable |
| cpu_dtack_n | output | 1 | Acknowledge to CPU, active low |
| ide_addr | output | REG_W | Drive register index |
| ide_cs0_n | output | 1 | Drive chip select, bank 0 |
| ide_cs1_n | output | 1 | Drive chip select, bank 1 |
| ide_rd_n | output | 1 | Drive read strobe |
| ide_wr_n | output | 1 | Drive write strobe |
| ide_din | input | DATA_W | Data from drive |
| ide_dout | output | DATA_W | Data to drive |
| ide_doe | output | 1 | Drive data bus drive enable |
| ide_rst_n | output | 1 | Drive reset, active low |

## Verification
The bench builds the bridge with `STROBE_CLKS`=4 and the default 3-bit register index and 16-bit bus. A strobe of four clocks keeps the setup clock, the strobe clocks and the acknowledge clock at distinct, countable sample positions, so a counter that is off by one, or a missing SETUP clock, shifts a measured index. The vectors cover both chip-select banks, both lanes alone and together, both alias mismatches and the three ways to miss the window.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_ACK,
        ST_SKIP
    } cyc_state_e;

endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode #(
    parameter int REG_W = 3,
    parameter int LANES = 2
) (
    input  logic             win_sel_n,
    input  logic             cpu_win_a,
    input  logic [REG_W+2:1] cpu_addr,
    input  logic             cpu_rw,
    input  logic [LANES-1:0] cpu_ds_n,
    output logic             hit,
    output logic             dir_ok,
    output logic             is_wr,
    output logic             bank,
    output logic [REG_W-1:0] reg_idx
);
    localparam int ALIAS_BIT = REG_W + 1;
    localparam int BANK_BIT  = REG_W + 2;

    always_comb begin
        hit     = !win_sel_n && cpu_win_a && !(&cpu_ds_n);
        is_wr   = cpu_addr[ALIAS_BIT];
        dir_ok  = (is_wr == !cpu_rw);
        bank    = cpu_addr[BANK_BIT];
        reg_idx = cpu_addr[REG_W:1];
    end

endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
    import ide_bridge_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic dir_ok,
    output logic load,
    output logic cap,
    output logic cs_en,
    output logic stb,
    output logic in_ack,
    output logic in_skip
);
    localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CLKS - 1);

    cyc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (hit) state_d = dir_ok ? ST_SETUP : ST_SKIP;
            ST_SETUP:  state_d = ST_ACTIVE;
            ST_ACTIVE: if (last) state_d = ST_ACK;
            ST_ACK:    if (!hit) state_d = ST_IDLE;
            ST_SKIP:   if (!hit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_ACTIVE) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        load    = 1'b0;
        cap     = 1'b0;
        cs_en   = 1'b0;
        stb     = 1'b0;
        in_ack  = 1'b0;
        in_skip = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = hit && dir_ok;
            ST_SETUP:  cs_en = 1'b1;
            ST_ACTIVE: begin
                cs_en = 1'b1;
                stb   = 1'b1;
                cap   = last;
            end
            ST_ACK: begin
                cs_en  = 1'b1;
                in_ack = 1'b1;
            end
            ST_SKIP:   in_skip = 1'b1;
            default:   ;
        endcase
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb) |-> ($past(cnt_q) == LAST)); // R7
    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $past(stb)); // R7

endmodule

// File: rtl/ide_lane_cap.sv
module ide_lane_cap #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              lane_req,
    input  logic              cap,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);
    logic              en_q;
    logic [LANE_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            data_q <= '0;
        end else begin
            if (load) en_q <= lane_req;
            if (cap)  data_q <= din;
        end
    end

    assign dout = en_q ? data_q : '0;

endmodule

// File: rtl/ide_window_bridge.sv
module ide_window_bridge #(
    parameter int REG_W       = 3,
    parameter int DATA_W      = 16,
    parameter int LANE_W      = 8,
    parameter int STROBE_CLKS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      win_sel_n,
    input  logic                      cpu_win_a,
    input  logic [REG_W+2:1]          cpu_addr,
    input  logic                      cpu_rw,
    input  logic [DATA_W/LANE_W-1:0]  cpu_ds_n,
    input  logic [DATA_W-1:0]         cpu_din,
    output logic [DATA_W-1:0]         cpu_dout,
    output logic                      cpu_doe,
    output logic                      cpu_dtack_n,
    output logic [REG_W-1:0]          ide_addr,
    output logic                      ide_cs0_n,
    output logic                      ide_cs1_n,
    output logic                      ide_rd_n,
    output logic                      ide_wr_n,
    input  logic [DATA_W-1:0]         ide_din,
    output logic [DATA_W-1:0]         ide_dout,
    output logic                      ide_doe,
    output logic                      ide_rst_n
);
    localparam int LANES = DATA_W / LANE_W;

    logic             hit, dir_ok, is_wr, bank;
    logic [REG_W-1:0] reg_idx;
    logic             load, cap, cs_en, stb, in_ack, in_skip;
    logic [REG_W-1:0] reg_q;
    logic             bank_q, wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic             stb_on;

    ide_win_decode #(.REG_W(REG_W), .LANES(LANES)) u_dec (
        .win_sel_n (win_sel_n),
        .cpu_win_a (cpu_win_a),
        .cpu_addr  (cpu_addr),
        .cpu_rw    (cpu_rw),
        .cpu_ds_n  (cpu_ds_n),
        .hit       (hit),
        .dir_ok    (dir_ok),
        .is_wr     (is_wr),
        .bank      (bank),
        .reg_idx   (reg_idx)
    );

    ide_cycle_fsm #(.STROBE_CLKS(STROBE_CLKS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .dir_ok  (dir_ok),
        .load    (load),
        .cap     (cap),
        .cs_en   (cs_en),
        .stb     (stb),
        .in_ack  (in_ack),
        .in_skip (in_skip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q   <= '0;
            bank_q  <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (load) begin
            reg_q   <= reg_idx;
            bank_q  <= bank;
            wr_q    <= is_wr;
            wdata_q <= cpu_din;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ide_lane_cap #(.LANE_W(LANE_W)) u_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .lane_req (!cpu_ds_n[g]),
            .cap      (cap),
            .din      (ide_din[g*LANE_W +: LANE_W]),
            .dout     (cpu_dout[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        ide_addr    = reg_q;
        ide_cs0_n   = !(cs_en && !bank_q);
        ide_cs1_n   = !(cs_en && bank_q);
        ide_rd_n    = !(stb && !wr_q);
        ide_wr_n    = !(stb && wr_q);
        ide_doe     = cs_en && wr_q;
        ide_dout    = wdata_q;
        cpu_dtack_n = !((in_ack || in_skip) && hit);
        cpu_doe     = in_ack && hit && !wr_q;
        ide_rst_n   = rst_n;
        stb_on      = !ide_rd_n || !ide_wr_n;
    end

    AST_STB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        stb_on |-> (!win_sel_n && cpu_win_a)); // R1
    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ide_cs0_n || ide_cs1_n); // R3
    AST_WR_NEEDS_CPU_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !ide_wr_n |-> !cpu_rw); // R5
    AST_SETUP_BEFORE_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_on) |-> ($stable({ide_addr, ide_cs0_n, ide_cs1_n}) && !(ide_cs0_n && ide_cs1_n))); // R6
    AST_HOLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ide_addr, ide_cs0_n, ide_cs1_n}) |-> (!stb_on && !$past(stb_on))); // R6
    AST_DOE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_doe |-> (!win_sel_n && cpu_win_a && cpu_rw)); // R8
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ide_doe |-> ide_rd_n); // R9

endmodule

// File: tb/ide_window_bridge_bench.sv
module ide_window_bridge_bench;
    localparam int STB = 4;

    typedef struct packed {
        logic [23:0] addr;
        logic        win;
        logic        rw;
        logic [1:0]  ds;
        logic [15:0] wdata;
        logic [15:0] rdata;
        logic [1:0]  kind;   // 0 ignored, 1 skip, 2 drive cycle
        logic        bank;
        logic [2:0]  reg_i;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{24'h50002E, 1'b1, 1'b1, 2'b11, 16'h0000, 16'hA55A, 2'd2, 1'b1, 3'd7, 16'hA55A},
        '{24'h500010, 1'b1, 1'b0, 2'b11, 16'hBEEF, 16'h0000, 2'd2, 1'b0, 3'd0, 16'h0000},
        '{24'h500006, 1'b1, 1'b1, 2'b01, 16'h0000, 16'h7788, 2'd2, 1'b0, 3'd3, 16'h0088},
        '{24'h50000A, 1'b1, 1'b1, 2'b10, 16'h0000, 16'hC3D4, 2'd2, 1'b0, 3'd5, 16'hC300},
        '{24'h500012, 1'b1, 1'b1, 2'b11, 16'h0000, 16'h1111, 2'd1, 1'b0, 3'd1, 16'h0000},
        '{24'h500004, 1'b1, 1'b0, 2'b11, 16'h2222, 16'h0000, 2'd1, 1'b0, 3'd2, 16'h0000},
        '{24'h400010, 1'b1, 1'b0, 2'b11, 16'h3333, 16'h0000, 2'd0, 1'b0, 3'd0, 16'h0000},
        '{24'h500010, 1'b0, 1'b0, 2'b11, 16'h4444, 16'h0000, 2'd0, 1'b0, 3'd0, 16'h0000},
        '{24'h500000, 1'b1, 1'b1, 2'b00, 16'h0000, 16'h5555, 2'd0, 1'b0, 3'd0, 16'h0000},
        '{24'h50003C, 1'b1, 1'b0, 2'b11, 16'h0F0F, 16'h0000, 2'd2, 1'b1, 3'd6, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        win_sel_n, cpu_win_a, cpu_rw;
    logic [5:1]  cpu_addr;
    logic [1:0]  cpu_ds_n;
    logic [15:0] cpu_din, cpu_dout, ide_din, ide_dout;
    logic        cpu_doe, cpu_dtack_n, ide_cs0_n, ide_cs1_n, ide_rd_n, ide_wr_n, ide_doe, ide_rst_n;
    logic [2:0]  ide_addr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    ide_window_bridge #(.REG_W(3), .DATA_W(16), .LANE_W(8), .STROBE_CLKS(STB)) u_ide_window_bridge (
        .clk(clk), .rst_n(rst_n), .win_sel_n(win_sel_n), .cpu_win_a(cpu_win_a),
        .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_ds_n(cpu_ds_n), .cpu_din(cpu_din),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .cpu_dtack_n(cpu_dtack_n),
        .ide_addr(ide_addr), .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
        .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n), .ide_din(ide_din),
        .ide_dout(ide_dout), .ide_doe(ide_doe), .ide_rst_n(ide_rst_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        win_sel_n = 1'b1;
        cpu_win_a = 1'b0;
        cpu_addr  = '0;
        cpu_rw    = 1'b1;
        cpu_ds_n  = 2'b11;
        cpu_din   = '0;
    endtask

    task automatic drive_vec(input vec_t v);
        win_sel_n = !v.win;
        cpu_win_a = v.addr[20];
        cpu_addr  = v.addr[5:1];
        cpu_rw    = v.rw;
        cpu_ds_n  = ~v.ds;
        cpu_din   = v.wdata;
        ide_din   = v.rdata;
    endtask

    task automatic run_vec(input int i);
        vec_t v = VEC[i];
        int first = 0, cnt = 0, dt = 0;
        bit saw_rd = 0, saw_wr = 0, set_stb_off = 0, rd_oe = 0, st_doe = 0;
        logic [1:0]  set_cs = 2'b11, st_cs = 2'b11, exp_cs;
        logic [2:0]  set_addr = '0, st_addr = '0;
        logic [15:0] st_dout = '0, rd_val = '0;
        exp_cs = v.bank ? 2'b01 : 2'b10;
        @(negedge clk);
        drive_vec(v);
        for (int s = 1; s <= STB + 6 && dt == 0; s++) begin
            @(negedge clk);
            if (s == 1) begin
                set_cs = {ide_cs1_n, ide_cs0_n};
                set_addr = ide_addr;
                set_stb_off = ide_rd_n && ide_wr_n;
            end
            if (!ide_rd_n) saw_rd = 1'b1;
            if (!ide_wr_n) saw_wr = 1'b1;
            if (!ide_rd_n || !ide_wr_n) begin
                cnt++;
                if (first == 0) begin
                    first = s;
                    st_addr = ide_addr;
                    st_cs = {ide_cs1_n, ide_cs0_n};
                    st_dout = ide_dout;
                    st_doe = ide_doe;
                end
            end
            if (!cpu_dtack_n) begin
                dt = s;
                rd_val = cpu_dout;
                rd_oe = cpu_doe;
            end
        end
        case (v.kind)
            2'd0: begin
                chk(dt == 0, "R1 no acknowledge outside window", dt, 0);
                chk(cnt == 0, "R1 no strobe outside window", cnt, 0);
                chk({ide_cs1_n, ide_cs0_n} == 2'b11, "R1 no chip select", {ide_cs1_n, ide_cs0_n}, 2'b11);
            end
            2'd1: begin
                chk(dt == 1, "R5 skip acknowledge after one clock", dt, 1);
                chk(cnt == 0, "R5 no strobe on alias mismatch", cnt, 0);
                chk(rd_oe == 0, "R5 bus not driven on skip", rd_oe, 0);
            end
            default: begin
                chk(set_stb_off && set_cs == exp_cs && set_addr == v.reg_i, "R6 setup clock",
                    {set_stb_off, set_cs, set_addr}, {1'b1, exp_cs, v.reg_i});
                chk(first == 2, "R6 strobe after setup", first, 2);
                chk(cnt == STB, "R7 strobe width", cnt, STB);
                chk(dt == STB + 2, "R7 acknowledge timing", dt, STB + 2);
                chk(st_addr == v.reg_i, "R2 register index", st_addr, v.reg_i);
                chk(st_cs == exp_cs, "R3 bank chip select", st_cs, exp_cs);
                chk(saw_rd == v.rw && saw_wr == !v.rw, "R4 strobe follows alias",
                    {saw_rd, saw_wr}, {v.rw, !v.rw});
                if (!v.rw)
                    chk(st_dout == v.wdata && st_doe, "R9 write data to drive",
                        {st_doe, st_dout}, {1'b1, v.wdata});
                else
                    chk(rd_val == v.exp_rd && rd_oe, "R8 read data and lanes",
                        {rd_oe, rd_val}, {1'b1, v.exp_rd});
            end
        endcase
        @(negedge clk);
        bus_idle();
        @(negedge clk);
        if (v.kind != 2'd0)
            chk(cpu_dtack_n && !cpu_doe && ide_cs0_n && ide_cs1_n, "R11 release after cycle",
                {cpu_dtack_n, cpu_doe, ide_cs0_n, ide_cs1_n}, 4'b1011);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bus_idle();
        ide_din = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ide_rst_n, "R10 drive reset follows system reset", ide_rst_n, 0);
        chk(ide_rd_n && ide_wr_n && ide_cs0_n && ide_cs1_n && cpu_dtack_n && !cpu_doe,
            "R10 idle outputs in reset", {ide_rd_n, ide_wr_n, ide_cs0_n, ide_cs1_n, cpu_dtack_n, cpu_doe}, 6'b111110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ide_rst_n, "R10 drive reset released", ide_rst_n, 1);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R11: hold the acknowledge, no second drive cycle
        @(negedge clk);
        drive_vec(VEC[0]);
        begin
            int strobes = 0;
            bit ack_lost = 0;
            for (int s = 1; s <= STB + 8; s++) begin
                @(negedge clk);
                if (!ide_rd_n || !ide_wr_n) strobes++;
                if (s > STB + 2 && cpu_dtack_n) ack_lost = 1'b1;
            end
            chk(strobes == STB, "R11 single drive cycle while held", strobes, STB);
            chk(!ack_lost, "R11 acknowledge held", ack_lost, 0);
        end
        bus_idle();
        #1;
        chk(cpu_dtack_n && !cpu_doe, "R11 immediate release", {cpu_dtack_n, cpu_doe}, 2'b10);
        @(negedge clk);

        // R10: reset in the middle of a strobe
        drive_vec(VEC[1]);
        repeat (3) @(negedge clk);
        chk(!ide_wr_n, "R10 strobe active before reset", ide_wr_n, 0);
        rst_n = 1'b0;
        #1;
        chk(ide_wr_n && ide_rd_n && ide_cs0_n && ide_cs1_n && !ide_rst_n, "R10 reset aborts cycle",
            {ide_wr_n, ide_rd_n, ide_cs0_n, ide_cs1_n, ide_rst_n}, 5'b11110);
        @(negedge clk);
        bus_idle();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cpu_dtack_n && ide_cs0_n && ide_cs1_n, "R10 idle after reset release",
            {cpu_dtack_n, ide_cs0_n, ide_cs1_n}, 3'b111);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule